// File: doc/BRIEF.md
# DRAM Off-Page Write Sequencer

This block runs one complete off-page write to a fast-page DRAM each time a start request is accepted. It drives a multiplexed address bus (row first, then column), the active-low RAS, CAS and WE strobes, and a write data bus with its output enable. When the cycle finishes it raises a one-tick done flag. The sequencer runs on an internal clock at twice the bus clock, so each internal tick is half a bus clock. Every strobe edge therefore falls on a half-bus-clock boundary.

Three 2-bit wait-state fields stretch three parts of the cycle. The precharge extension P lengthens the RAS-high phase. The row-hold extension R lengthens the time from RAS falling to CAS falling. The access extension D lengthens CAS low. An external WAIT input adds whole bus clocks to the CAS-low phase only. The fields, the addresses and the data are captured when the start is accepted. A start that arrives while a cycle is in progress is ignored.

In what follows, tick 0 is the first internal tick after the accepting edge. w is the number of WAIT samples found asserted.

Top module: `dramw_seq`

## Requirements
- R1: After reset, ras_n_o, cas_n_o and we_n_o are 1, and dq_oe_o and done_o are 0.
- R2: RAS falls at tick 1+2P. The row address is on dram_addr_o from tick 0 through tick 1+2P+2R.
- R3: The column address appears at tick 2+2P+2R, one tick before CAS falls at tick 3+2P+2R.
- R4: CAS stays low for 2+2D+2w ticks. WAIT is sampled in the last tick of each two-tick slot that would otherwise end CAS low, and each asserted sample adds two ticks.
- R5: RAS rises one tick after CAS rises. RAS is therefore low for 5+2R+2D+2w ticks, and the whole cycle lasts 6+2P+2R+2D+2w ticks.
- R6: WE is low from tick 1 until CAS rises, so it falls 2+2P+2R ticks before CAS falls.
- R7: dq_oe_o is 1 from tick 0 until RAS rises, and dq_o carries the captured write data throughout that window.
- R8: done_o is high for exactly one tick per cycle: the tick in which CAS has risen and RAS is still low.
- R9: A start request during a cycle is ignored. The wait fields, addresses and data captured at acceptance govern the whole cycle, even if the inputs change later.
- R10: WAIT asserted outside the CAS-low phase adds no time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, twice the bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| wait_i | input | 1 | Wait request; stretches CAS low |
| prech_ws_i | input | WS_W | Precharge extension P |
| rowh_ws_i | input | WS_W | Row-hold extension R |
| acc_ws_i | input | WS_W | Access extension D |
| row_addr_i | input | ADDR_W | Row address |
| col_addr_i | input | ADDR_W | Column address |
| wdata_i | input | DATA_W | Write data |
| dram_addr_o | output | ADDR_W | Multiplexed DRAM address |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dq_o | output | DATA_W | Write data bus |
| dq_oe_o | output | 1 | Data bus output enable |
| done_o | output | 1 | One-tick end-of-cycle flag |

## Verification
The checker enforces the strobe nesting on every cycle:
- CAS is only low inside RAS low.
- WE covers CAS.
- The output enable covers RAS low.
- done lasts a single tick and always precedes the rise of RAS.
- The address is stable at both falling strobes.

The exact tick positions of each edge depend on the captured wait fields and on how many WAIT samples hit the CAS phase. Only the bench scenarios can show those positions. The scenarios also show that a mid-cycle start and changed inputs leave the cycle untouched, and that WAIT outside CAS low adds nothing.

// File: rtl/dramw_pkg.sv
package dramw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_ROWH,
      ST_R2C,
      ST_CAS,
      ST_REC
   } dramw_state_e;

endpackage

// File: rtl/dramw_fsm.sv
module dramw_fsm
   import dramw_pkg::*;
#(
   parameter int WS_W = 2
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         start_i,
   input  logic         wait_i,
   input  logic [WS_W-1:0] prech_ws_i,
   input  logic [WS_W-1:0] rowh_ws_i,
   input  logic [WS_W-1:0] acc_ws_i,
   output dramw_state_e state_o,
   output dramw_state_e state_n_o,
   output logic         accept_o
);
   localparam int CNT_W = WS_W + 2;

   dramw_state_e state_q, state_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [WS_W-1:0]  rowh_q, acc_q;

   // two ticks per wait state, plus an optional extra tick
   function automatic logic [CNT_W-1:0] ticks(input logic [WS_W-1:0] ws, input logic extra);
      return {1'b0, ws, extra};
   endfunction

   assign accept_o = (state_q == ST_IDLE) && start_i;

   always_comb begin
      state_n = state_q;
      cnt_n   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            state_n = ST_PRE;
            cnt_n   = ticks(prech_ws_i, 1'b0);
         end
         ST_PRE: if (cnt_q == '0) begin
            state_n = ST_ROWH;
            cnt_n   = ticks(rowh_q, 1'b0);
         end
         ST_ROWH: if (cnt_q == '0) begin
            state_n = ST_R2C;
            cnt_n   = '0;
         end
         ST_R2C: begin
            state_n = ST_CAS;
            cnt_n   = ticks(acc_q, 1'b1);
         end
         ST_CAS: if (cnt_q == '0) begin
            if (wait_i) begin
               cnt_n = CNT_W'(1);
            end else begin
               state_n = ST_REC;
               cnt_n   = '0;
            end
         end
         ST_REC: begin
            state_n = ST_IDLE;
            cnt_n   = '0;
         end
         default: begin
            state_n = ST_IDLE;
            cnt_n   = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rowh_q  <= '0;
         acc_q   <= '0;
      end else begin
         state_q <= state_n;
         cnt_q   <= cnt_n;
         if (accept_o) begin
            rowh_q <= rowh_ws_i;
            acc_q  <= acc_ws_i;
         end
      end
   end

   assign state_o   = state_q;
   assign state_n_o = state_n;
endmodule

// File: rtl/dramw_capture.sv
module dramw_capture #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              accept_i,
   input  logic [ADDR_W-1:0] row_addr_i,
   input  logic [ADDR_W-1:0] col_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [ADDR_W-1:0] row_now_o,
   output logic [ADDR_W-1:0] col_q_o,
   output logic [DATA_W-1:0] data_now_o
);
   logic [ADDR_W-1:0] row_q, col_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         row_q  <= '0;
         col_q  <= '0;
         data_q <= '0;
      end else if (accept_i) begin
         row_q  <= row_addr_i;
         col_q  <= col_addr_i;
         data_q <= wdata_i;
      end
   end

   // on the accepting edge the fresh values feed the output registers directly
   assign row_now_o  = accept_i ? row_addr_i : row_q;
   assign data_now_o = accept_i ? wdata_i : data_q;
   assign col_q_o    = col_q;
endmodule

// File: rtl/dramw_pins.sv
module dramw_pins
   import dramw_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 16,
   parameter bit ZERO_IDLE_DQ = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  dramw_state_e      state_i,
   input  dramw_state_e      state_n_i,
   input  logic [ADDR_W-1:0] row_i,
   input  logic [ADDR_W-1:0] col_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [ADDR_W-1:0] dram_addr_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe_o,
   output logic              done_o
);
   logic ras_low_n, cas_low_n, we_low_n, oe_n, row_phase_n;

   always_comb begin
      row_phase_n = (state_n_i == ST_PRE) || (state_n_i == ST_ROWH);
      ras_low_n   = (state_n_i == ST_ROWH) || (state_n_i == ST_R2C) ||
                    (state_n_i == ST_CAS)  || (state_n_i == ST_REC);
      cas_low_n   = (state_n_i == ST_CAS);
      // WE skips the first precharge tick (the one entered from idle)
      we_low_n    = ((state_n_i == ST_PRE) && (state_i != ST_IDLE)) ||
                    (state_n_i == ST_ROWH) || (state_n_i == ST_R2C) ||
                    (state_n_i == ST_CAS);
      oe_n        = (state_n_i != ST_IDLE);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         dram_addr_o <= '0;
         ras_n_o     <= 1'b1;
         cas_n_o     <= 1'b1;
         we_n_o      <= 1'b1;
         dq_oe_o     <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         dram_addr_o <= row_phase_n ? row_i : col_i;
         ras_n_o     <= ~ras_low_n;
         cas_n_o     <= ~cas_low_n;
         we_n_o      <= ~we_low_n;
         dq_oe_o     <= oe_n;
         done_o      <= (state_n_i == ST_REC);
      end
   end

   generate
      if (ZERO_IDLE_DQ) begin : g_dq_zero
         always_ff @(posedge clk_i) begin
            if (rst_i)     dq_o <= '0;
            else if (oe_n) dq_o <= data_i;
            else           dq_o <= '0;
         end
      end else begin : g_dq_hold
         always_ff @(posedge clk_i) begin
            if (rst_i)     dq_o <= '0;
            else if (oe_n) dq_o <= data_i;
         end
      end
   endgenerate
endmodule

// File: rtl/dramw_seq.sv
module dramw_seq
   import dramw_pkg::*;
#(
   parameter int WS_W         = 2,
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 16,
   parameter bit ZERO_IDLE_DQ = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic              wait_i,
   input  logic [WS_W-1:0]   prech_ws_i,
   input  logic [WS_W-1:0]   rowh_ws_i,
   input  logic [WS_W-1:0]   acc_ws_i,
   input  logic [ADDR_W-1:0] row_addr_i,
   input  logic [ADDR_W-1:0] col_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [ADDR_W-1:0] dram_addr_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe_o,
   output logic              done_o
);
   generate
      if (WS_W < 1 || WS_W > 4) begin : g_bad_ws
         $error("dramw_seq: WS_W must be 1..4");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("dramw_seq: bus widths must be positive");
      end
   endgenerate

   dramw_state_e      state, state_n;
   logic              accept;
   logic [ADDR_W-1:0] row_now, col_q;
   logic [DATA_W-1:0] data_now;

   dramw_fsm #(.WS_W(WS_W)) u_fsm (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .start_i    (start_i),
      .wait_i     (wait_i),
      .prech_ws_i (prech_ws_i),
      .rowh_ws_i  (rowh_ws_i),
      .acc_ws_i   (acc_ws_i),
      .state_o    (state),
      .state_n_o  (state_n),
      .accept_o   (accept)
   );

   dramw_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .accept_i   (accept),
      .row_addr_i (row_addr_i),
      .col_addr_i (col_addr_i),
      .wdata_i    (wdata_i),
      .row_now_o  (row_now),
      .col_q_o    (col_q),
      .data_now_o (data_now)
   );

   dramw_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZERO_IDLE_DQ(ZERO_IDLE_DQ)) u_pins (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .state_i     (state),
      .state_n_i   (state_n),
      .row_i       (row_now),
      .col_i       (col_q),
      .data_i      (data_now),
      .dram_addr_o (dram_addr_o),
      .ras_n_o     (ras_n_o),
      .cas_n_o     (cas_n_o),
      .we_n_o      (we_n_o),
      .dq_o        (dq_o),
      .dq_oe_o     (dq_oe_o),
      .done_o      (done_o)
   );
endmodule

// File: rtl/dramw_seq_chk.sv
module dramw_seq_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [ADDR_W-1:0] dram_addr_o,
   input logic              ras_n_o,
   input logic              cas_n_o,
   input logic              we_n_o,
   input logic              dq_oe_o,
   input logic              done_o
);
   a_r1_reset_idle: assert property (@(posedge clk_i)
      $past(rst_i) |-> (ras_n_o && cas_n_o && we_n_o && !dq_oe_o && !done_o));

   a_r2_row_stable_at_ras: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(ras_n_o) |-> $stable(dram_addr_o));

   a_r3_col_stable_at_cas: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(cas_n_o) |-> $stable(dram_addr_o));

   a_r4_cas_inside_ras: assert property (@(posedge clk_i) disable iff (rst_i)
      !cas_n_o |-> !ras_n_o);

   a_r5_ras_rise_after_done: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(ras_n_o) |-> $past(done_o));

   a_r6_we_covers_cas: assert property (@(posedge clk_i) disable iff (rst_i)
      !cas_n_o |-> !we_n_o);

   a_r7_oe_covers_ras: assert property (@(posedge clk_i) disable iff (rst_i)
      !ras_n_o |-> dq_oe_o);

   a_r8_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);

   a_r8_done_in_recover: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> (cas_n_o && !ras_n_o && we_n_o));
endmodule

bind dramw_seq dramw_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .dram_addr_o (dram_addr_o),
   .ras_n_o     (ras_n_o),
   .cas_n_o     (cas_n_o),
   .we_n_o      (we_n_o),
   .dq_oe_o     (dq_oe_o),
   .done_o      (done_o)
);

// File: tb/sim_dramw_seq.sv
module sim_dramw_seq;
   localparam int WS_W = 2, ADDR_W = 12, DATA_W = 16;

   logic clk = 1'b0, rst = 1'b1;
   logic start = 1'b0, wt = 1'b0;
   logic [WS_W-1:0]   p_in = '0, r_in = '0, d_in = '0;
   logic [ADDR_W-1:0] row_in = '0, col_in = '0;
   logic [DATA_W-1:0] dat_in = '0;
   logic [ADDR_W-1:0] addr;
   logic ras_n, cas_n, we_n, oe, done;
   logic [DATA_W-1:0] dq;

   int checks = 0, errors = 0, cycles = 0;

   always #4 clk = ~clk;

   dramw_seq #(.WS_W(WS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
      .clk_i(clk), .rst_i(rst), .start_i(start), .wait_i(wt),
      .prech_ws_i(p_in), .rowh_ws_i(r_in), .acc_ws_i(d_in),
      .row_addr_i(row_in), .col_addr_i(col_in), .wdata_i(dat_in),
      .dram_addr_o(addr), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
      .dq_o(dq), .dq_oe_o(oe), .done_o(done));

   typedef struct {
      int p, r, d, w;
      logic [ADDR_W-1:0] row, col;
      logic [DATA_W-1:0] data;
   } exp_t;
   exp_t sb[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: tick 0 is the first tick with the output enable high
   int t, ras_f, col_t, cas_f, cas_r, we_f, we_r, done_t, done_n;
   bit in_cyc = 0, row_bad, dq_bad;
   logic [ADDR_W-1:0] col_seen;

   always @(negedge clk) begin
      if (!rst) begin
         if (oe) begin
            if (!in_cyc) begin
               in_cyc = 1; t = 0;
               ras_f = -1; col_t = -1; cas_f = -1; cas_r = -1;
               we_f = -1; we_r = -1; done_t = -1; done_n = 0;
               row_bad = 0; dq_bad = 0; col_seen = '0;
            end else t++;
            if (sb.size() > 0) begin
               if (col_t < 0 && addr != sb[0].row) col_t = t;
               if (col_t < 0 && addr != sb[0].row && t <= 0) row_bad = 1;
               if (dq != sb[0].data) dq_bad = 1;
            end
            if (!ras_n && ras_f < 0) ras_f = t;
            if (!cas_n && cas_f < 0) begin cas_f = t; col_seen = addr; end
            if (cas_n && cas_f >= 0 && cas_r < 0) cas_r = t;
            if (!we_n && we_f < 0) we_f = t;
            if (we_n && we_f >= 0 && we_r < 0) we_r = t;
            if (done) begin done_n++; if (done_t < 0) done_t = t; end
         end else if (in_cyc) begin
            in_cyc = 0;
            cycles++;
            if (sb.size() == 0) begin
               chk(0, "R9 spurious cycle", cycles, 0);
            end else begin
               exp_t e;
               int cf, cr;
               e = sb.pop_front();
               cf = 3 + 2*e.p + 2*e.r;
               cr = cf + 2 + 2*e.d + 2*e.w;
               chk(ras_f == 1 + 2*e.p, "R2 ras fall tick", ras_f, 1 + 2*e.p);
               chk(!row_bad, "R2 row address at tick 0", 0, 1);
               chk(col_t == 2 + 2*e.p + 2*e.r, "R3 column address tick", col_t, 2 + 2*e.p + 2*e.r);
               chk(col_seen == e.col, "R3 column value at cas fall", int'(col_seen), int'(e.col));
               chk(cas_f == cf, "R3 cas fall tick", cas_f, cf);
               chk(cas_r - cas_f == 2 + 2*e.d + 2*e.w, "R4 R10 cas low ticks", cas_r - cas_f, 2 + 2*e.d + 2*e.w);
               chk(t + 1 == cr + 1, "R5 cycle length", t + 1, cr + 1);
               chk(ras_n == 1'b1, "R5 ras high at end", int'(ras_n), 1);
               chk(we_f == 1 && we_r == cr, "R6 we window", we_f*1000 + we_r, 1000 + cr);
               chk(!dq_bad, "R7 data value in window", 0, 1);
               chk(done_n == 1 && done_t == cr, "R8 done tick", done_n*1000 + done_t, 1000 + cr);
            end
         end
      end
   end

   task automatic run_cycle(input int p, r, d, w,
                            input logic [ADDR_W-1:0] row, col,
                            input logic [DATA_W-1:0] data,
                            input bit pre_wait, input bit mid_start);
      exp_t e;
      e.p = p; e.r = r; e.d = d; e.w = w; e.row = row; e.col = col; e.data = data;
      @(negedge clk);
      p_in = WS_W'(p); r_in = WS_W'(r); d_in = WS_W'(d);
      row_in = row; col_in = col; dat_in = data;
      sb.push_back(e);
      start = 1;
      @(negedge clk);
      start = 0;
      if (pre_wait) wt = 1;
      if (mid_start) begin
         // R9: new start and altered inputs while busy
         p_in = ~p_in; r_in = ~r_in; d_in = ~d_in;
         row_in = ~row; col_in = ~col; dat_in = ~data;
         start = 1;
         @(negedge clk);
         @(negedge clk);
         start = 0;
      end
      while (cas_n) @(negedge clk);
      wt = (w > 0);
      if (w > 0) repeat (2*d + 2*w) @(negedge clk);
      wt = 0;
      while (oe) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state while reset is held
      chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
      chk(!oe && !done, "R1 oe and done low in reset", {oe, done}, 0);
      rst = 0;
      repeat (2) @(negedge clk);
      chk(ras_n && cas_n && we_n && !oe && !done, "R1 idle after reset",
          {ras_n, cas_n, we_n, oe, done}, 5'b11100);
      run_cycle(0, 0, 0, 0, 12'h0A1, 12'h0B2, 16'h1234, 0, 0);
      run_cycle(3, 3, 3, 0, 12'h3C4, 12'h5D6, 16'hBEEF, 0, 0);
      run_cycle(1, 2, 0, 2, 12'h111, 12'h222, 16'h00FF, 0, 0);
      run_cycle(2, 0, 3, 1, 12'hFFF, 12'h000, 16'hA5A5, 0, 0);
      run_cycle(1, 1, 1, 0, 12'h700, 12'h070, 16'h5555, 1, 0); // R10
      run_cycle(2, 1, 1, 1, 12'h123, 12'h456, 16'h7E7E, 0, 1); // R9
      run_cycle(0, 3, 0, 3, 12'h800, 12'h008, 16'hC3C3, 0, 0);
      repeat (10) @(negedge clk);
      chk(sb.size() == 0 && cycles == 7, "R9 cycle count", cycles, 7);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule